// File: doc/BRIEF.md
# System control register bank

This block is a 4 KiB window of 32-bit global control and status words. It sits on an APB-style slave port and always answers in a single cycle. Each implemented word has a fixed write policy: plain read/write, read-only, write-one-to-clear or write-one-to-set. A cold reset loads a built-in value into every word. Three of these values come from outside the table. The strap word takes the level of a strap input bus. The module-disable word takes the level of a disable-mask input bus. The third control word carries a field that encodes the installed DRAM size, which is given as an elaboration parameter.

Every aligned word from 0x000 to 0x144 is backed by a flop register, including the offsets that have no named function. An offset past 0x144 reads as zero and ignores writes. An access with a non-zero byte offset, or any access past 0x144, returns an error response. A write to a read-only word also returns an error response. The block does not model the pin muxing, PHY or interrupt effects that these words would drive in a real chip.

Top module: `sysctl_bank`

## Requirements
- R1: A cold reset (synchronous, `rst_n` low on a clock edge) loads constant values into these words: 0x000 = 0x04A92750, 0x014 = 0x0000FFFF, 0x038 = 0x00000003, 0x03C = 0x0000035E, 0x050 = 0x0000004E, 0x060 = 0x00080000, 0x06C = 0x80000000, 0x078 = 0x000000C0, 0x098 = 0x5A00F3CF, 0x13C = 0x00000008, and 0x034730E4 in both 0x140 and 0x144. Every other word below 0x148 resets to 0, apart from the three words covered by R2 and R3.
- R2: At cold reset, word 0x004 loads `strap_i` and word 0x07C loads `mod_dis_i`. Outside reset these inputs have no effect.
- R3: Word 0x09C resets to 0x00001002 OR (log2(DRAM_MB/128) << 8). DRAM_MB must be a power of two from 128 to 2048. Any other value stops elaboration.
- R4: Words 0x000, 0x004 and 0x040 are read-only. A write to one of them leaves it unchanged and raises `pslverr` in the access cycle.
- R5: Words 0x06C and 0x0D4 are write-one-to-clear: new = old AND NOT `pwdata`.
- R6: Words 0x070 and 0x07C are write-one-to-set: new = old OR `pwdata`. No write can clear a bit.
- R7: Every other aligned word below 0x148, named or not, stores `pwdata` on a write. A read in the access cycle (`psel`, `penable`, `pwrite` low) returns the stored word on `prdata`.
- R8: An aligned access at 0x148 or above reads 0, raises `pslverr`, and leaves every stored word unchanged.
- R9: An access with `paddr[1:0]` not zero raises `pslverr`, reads 0, and changes no stored word.
- R10: `pready` is always 1. `pslverr` stays low for legal reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous cold reset |
| strap_i | input | 32 | Strap levels, sampled into word 0x004 at reset |
| mod_dis_i | input | 32 | Module-disable mask, sampled into word 0x07C at reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response for the current access |

## Verification
The assertions hold on every cycle after reset. They check that the read-only words never change and that the clear-only words never gain a bit. They check that the set-only words never lose a bit. They check that a misaligned access changes no state, and that out-of-range or misaligned accesses, and writes to read-only words, always raise an error. Only the bench's scenarios can show the exact reset table, the strap and mask capture, and the DRAM field encoding. The bench also shows the per-word values after full sweeps of all-ones and patterned writes, and that storage is intact after the out-of-range sweep.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_WORDS = 82;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

    localparam int IDX_ID     = 0;
    localparam int IDX_STRAP  = 1;
    localparam int IDX_ISTAT  = 16;
    localparam int IDX_RSTST  = 27;
    localparam int IDX_LOCK   = 28;
    localparam int IDX_MDIS   = 31;
    localparam int IDX_CTL3   = 39;
    localparam int IDX_CPST   = 53;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        POL_RW  = 2'd0,
        POL_RO  = 2'd1,
        POL_W1C = 2'd2,
        POL_W1S = 2'd3
    } wpol_e;

    typedef struct packed {
        word_t [NUM_WORDS-1:0] regs;
    } bank_t;

    function automatic wpol_e policy_of(int idx);
        case (idx)
            IDX_ID, IDX_STRAP, IDX_ISTAT: return POL_RO;
            IDX_RSTST, IDX_CPST:          return POL_W1C;
            IDX_LOCK, IDX_MDIS:           return POL_W1S;
            default:                      return POL_RW;
        endcase
    endfunction

    function automatic word_t const_reset(int idx);
        case (idx)
            0:       return 32'h04A9_2750;
            5:       return 32'h0000_FFFF;
            14:      return 32'h0000_0003;
            15:      return 32'h0000_035E;
            20:      return 32'h0000_004E;
            24:      return 32'h0008_0000;
            27:      return 32'h8000_0000;
            30:      return 32'h0000_00C0;
            38:      return 32'h5A00_F3CF;
            79:      return 32'h0000_0008;
            80, 81:  return 32'h0347_30E4;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              aligned
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        idx      = word[IDX_W-1:0];
        in_range = int'(word) < int'(NUM_WORDS);
        aligned  = (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/sysctl_wpolicy.sv
`timescale 1ns/1ps
module sysctl_wpolicy
    import sysctl_pkg::*;
(
    input  wpol_e pol,
    input  word_t old_val,
    input  word_t wdata,
    output word_t new_val,
    output logic  reject
);
    always_comb begin
        reject  = 1'b0;
        new_val = wdata;
        case (pol)
            POL_RO: begin
                reject  = 1'b1;
                new_val = old_val;
            end
            POL_W1C: new_val = old_val & ~wdata;
            POL_W1S: new_val = old_val | wdata;
            default: new_val = wdata;
        endcase
    end
endmodule

// File: rtl/sysctl_reset_table.sv
`timescale 1ns/1ps
module sysctl_reset_table
    import sysctl_pkg::*;
#(
    parameter int unsigned DRAM_MB = 512
) (
    input  word_t strap_i,
    input  word_t mod_dis_i,
    output bank_t rst_val
);
    localparam int unsigned MIN_MB   = 128;
    localparam int unsigned MAX_MB   = 2048;
    localparam bit          LEGAL    = (DRAM_MB >= MIN_MB) && (DRAM_MB <= MAX_MB)
                                       && ((DRAM_MB & (DRAM_MB - 1)) == 0);
    localparam int unsigned DRAM_LOG = $clog2(DRAM_MB / MIN_MB);
    localparam word_t       CTL3_RST = 32'h0000_1002 | (word_t'(DRAM_LOG) << 8);

    if (!LEGAL) begin : g_bad_dram
        $error("sysctl_reset_table: DRAM_MB must be a power of two in 128..2048");
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == IDX_STRAP) begin : g_strap
            assign rst_val.regs[i] = strap_i;
        end else if (i == IDX_MDIS) begin : g_mdis
            assign rst_val.regs[i] = mod_dis_i;
        end else if (i == IDX_CTL3) begin : g_ctl3
            assign rst_val.regs[i] = CTL3_RST;
        end else begin : g_const
            assign rst_val.regs[i] = const_reset(i);
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
`timescale 1ns/1ps
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DRAM_MB = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       strap_i,
    input  logic [31:0]       mod_dis_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr
);
    bank_t            q, d;
    bank_t            rst_val;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             aligned;
    wpol_e            pol;
    word_t            old_val;
    word_t            new_val;
    logic             reject;
    logic             access;
    logic             legal;

    sysctl_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr     (paddr),
        .idx      (idx),
        .in_range (in_range),
        .aligned  (aligned)
    );

    sysctl_wpolicy i_wpolicy (
        .pol     (pol),
        .old_val (old_val),
        .wdata   (pwdata),
        .new_val (new_val),
        .reject  (reject)
    );

    sysctl_reset_table #(.DRAM_MB(DRAM_MB)) i_reset_table (
        .strap_i   (strap_i),
        .mod_dis_i (mod_dis_i),
        .rst_val   (rst_val)
    );

    always_comb begin
        d       = q;
        access  = psel & penable;
        legal   = aligned & in_range;
        pol     = in_range ? policy_of(int'(idx)) : POL_RO;
        old_val = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (idx == IDX_W'(i)) begin
                old_val = q.regs[i];
            end
        end

        if (access && pwrite && legal && !reject) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (idx == IDX_W'(i)) begin
                    d.regs[i] = new_val;
                end
            end
        end

        pready  = 1'b1;
        pslverr = access & (!legal | (pwrite & reject));
        prdata  = (access && !pwrite && legal) ? old_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= rst_val;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
`timescale 1ns/1ps
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pslverr,
    input bank_t             bank
);
    logic acc;
    logic mis;
    logic oob;
    logic ro_hit;

    always_comb begin
        acc    = psel & penable;
        mis    = paddr[1:0] != 2'b00;
        oob    = int'(paddr[ADDR_W-1:2]) >= int'(NUM_WORDS);
        ro_hit = (int'(paddr[ADDR_W-1:2]) == IDX_ID) || (int'(paddr[ADDR_W-1:2]) == IDX_STRAP)
                 || (int'(paddr[ADDR_W-1:2]) == IDX_ISTAT);
    end

    // R4: read-only words hold their reset contents
    p_ro_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(bank.regs[IDX_ID]) && $stable(bank.regs[IDX_STRAP])
                  && $stable(bank.regs[IDX_ISTAT])));

    // R4: writing a read-only word is flagged
    p_ro_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && !mis && ro_hit) |-> pslverr);

    // R5: clear-only words never gain a bit
    p_w1c_noset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((bank.regs[IDX_RSTST] & ~$past(bank.regs[IDX_RSTST])) == '0)
                  && ((bank.regs[IDX_CPST] & ~$past(bank.regs[IDX_CPST])) == '0)));

    // R6: set-only words never lose a bit
    p_w1s_noclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~bank.regs[IDX_LOCK] & $past(bank.regs[IDX_LOCK])) == '0)
                  && ((~bank.regs[IDX_MDIS] & $past(bank.regs[IDX_MDIS])) == '0)));

    // R8: out-of-range access reads zero with an error
    p_oob_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !mis && oob) |-> (pslverr && prdata == '0));

    // R9: misaligned access reports an error and reads zero
    p_mis_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mis) |-> (pslverr && prdata == '0));

    // R9: misaligned access leaves all words unchanged
    p_mis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mis) |=> $stable(bank));
endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pslverr (pslverr),
    .bank    (q)
);

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;
    localparam int NW      = 82;
    localparam int DRAM_MB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] strap_i = '0;
    logic [31:0] mod_dis_i = '0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model [NW];

    always #10 clk = ~clk;

    sysctl_bank #(.ADDR_W(12), .DRAM_MB(DRAM_MB)) i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .mod_dis_i(mod_dis_i),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int i);
        if (i == 1 || i == 31) return "R2";
        if (i == 39) return "R3";
        if (i == 0 || i == 16) return "R4";
        if (i == 27 || i == 53) return "R5";
        if (i == 28) return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] ctl3_expect();
        int lg = 0;
        int r = DRAM_MB / 128;
        while (r > 1) begin
            r = r / 2;
            lg++;
        end
        return 32'h0000_1002 | (32'(lg) << 8);
    endfunction

    function automatic logic [31:0] rst_expect(int i, logic [31:0] st, logic [31:0] md);
        case (i)
            0:  return 32'h04A9_2750;
            1:  return st;
            5:  return 32'h0000_FFFF;
            14: return 32'h0000_0003;
            15: return 32'h0000_035E;
            20: return 32'h0000_004E;
            24: return 32'h0000_0001 << 19;
            27: return 32'h8000_0000;
            30: return 32'h0000_00C0;
            31: return md;
            38: return 32'h5A00_F3CF;
            39: return ctl3_expect();
            79: return 32'h0000_0008;
            80: return 32'h0347_30E4;
            81: return 32'h0347_30E4;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] apply(int i, logic [31:0] old, logic [31:0] wd);
        if (i == 0 || i == 1 || i == 16) return old;
        if (i == 27 || i == 53) return old & ~wd;
        if (i == 28 || i == 31) return old | wd;
        return wd;
    endfunction

    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic err, output logic rdy);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr; rdy = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic do_reset(input logic [31:0] st, input logic [31:0] md);
        @(negedge clk);
        strap_i = st; mod_dis_i = md; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) model[i] = rst_expect(i, st, md);
    endtask

    task automatic read_all(input string tag);
        logic [31:0] rd;
        logic e, r;
        for (int i = 0; i < NW; i++) begin
            apb(1'b0, 12'(i * 4), '0, rd, e, r);
            chk(req_of(i), rd, model[i], $sformatf("%s word %0d", tag, i));
            chk("R10", {31'b0, e}, 32'd0, $sformatf("%s read err word %0d", tag, i));
        end
    endtask

    task automatic write_all(input int pass);
        logic [31:0] rd, wd;
        logic e, r;
        for (int i = 0; i < NW; i++) begin
            wd = (pass == 0) ? 32'hFFFF_FFFF : ((32'(i) * 32'h0102_0409) ^ 32'h5A5A_C3C3);
            apb(1'b1, 12'(i * 4), wd, rd, e, r);
            model[i] = apply(i, model[i], wd);
            if (i == 0 || i == 1 || i == 16)
                chk("R4", {31'b0, e}, 32'd1, $sformatf("read-only write err word %0d", i));
            else
                chk("R10", {31'b0, e}, 32'd0, $sformatf("write err word %0d", i));
            chk("R10", {31'b0, r}, 32'd1, "pready");
        end
    endtask

    initial begin
        logic [31:0] rd;
        logic e, r;

        // R1, R2, R3: reset contents
        do_reset(32'hDEAD_0001, 32'h0000_0003);
        read_all("reset");
        chk("R3", model[39], 32'h0000_1202, "dram field at 512 MiB");

        // R2: strap inputs ignored outside reset
        strap_i = 32'h1111_1111; mod_dis_i = 32'h2222_2222;
        apb(1'b0, 12'h004, '0, rd, e, r);
        chk("R2", rd, 32'hDEAD_0001, "strap word after input change");
        apb(1'b0, 12'h07C, '0, rd, e, r);
        chk("R2", rd, 32'h0000_0003, "disable word after input change");

        // R4..R7: sweeps with all ones then a pattern
        write_all(0);
        read_all("ones");
        write_all(1);
        read_all("pattern");

        // R5: clear a single bit on a clear-only word
        do_reset(32'h0, 32'h0);
        apb(1'b1, 12'h06C, 32'h0000_0001, rd, e, r);
        apb(1'b0, 12'h06C, '0, rd, e, r);
        chk("R5", rd, 32'h8000_0000, "clear of a zero bit");
        apb(1'b1, 12'h06C, 32'h8000_0000, rd, e, r);
        apb(1'b0, 12'h06C, '0, rd, e, r);
        chk("R5", rd, 32'h0000_0000, "clear of the reset bit");
        model[27] = '0;

        // R6: zero write does not clear set-only bits
        apb(1'b1, 12'h070, 32'h0000_00A0, rd, e, r);
        apb(1'b1, 12'h070, 32'h0000_0000, rd, e, r);
        apb(1'b0, 12'h070, '0, rd, e, r);
        chk("R6", rd, 32'h0000_00A0, "set-only survives zero write");
        model[28] = 32'h0000_00A0;

        // R8: out-of-range sweep
        for (int a = NW * 4; a <= 12'hFFC; a += 4) begin
            apb(1'b1, 12'(a), 32'hFFFF_FFFF, rd, e, r);
            chk("R8", {31'b0, e}, 32'd1, $sformatf("oob write err %03h", a));
            apb(1'b0, 12'(a), '0, rd, e, r);
            chk("R8", rd, 32'd0, $sformatf("oob read %03h", a));
            chk("R8", {31'b0, e}, 32'd1, $sformatf("oob read err %03h", a));
        end
        read_all("after oob R8");

        // R9: misaligned accesses
        for (int k = 0; k < 4; k++) begin
            int idx = (k == 0) ? 2 : (k == 1) ? 27 : (k == 2) ? 28 : 81;
            for (int o = 1; o < 4; o++) begin
                apb(1'b1, 12'(idx * 4 + o), 32'h0F0F_F0F0, rd, e, r);
                chk("R9", {31'b0, e}, 32'd1, "misaligned write err");
                apb(1'b0, 12'(idx * 4 + o), '0, rd, e, r);
                chk("R9", rd, 32'd0, "misaligned read data");
                chk("R9", {31'b0, e}, 32'd1, "misaligned read err");
            end
            apb(1'b0, 12'(idx * 4), '0, rd, e, r);
            chk("R9", rd, model[idx], $sformatf("word %0d after misaligned", idx));
        end

        // R2: second cold reset with new strap values
        do_reset(32'h1357_9BDF, 32'h0000_00F0);
        read_all("second reset R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule